// File: doc/BRIEF.md
# Programmable PIO Strobe Timing Sequencer

This block runs single programmed-I/O bus cycles to a register in an external peripheral. A CPU-side requester presents an address, a read/write flag, write data and a configuration word, and raises a request. The sequencer then asserts chip select and walks through three timed phases. The first is setup, with address and select valid. The second is the strobe, with the read or write strobe active. The third is hold, where select stays valid after the strobe. It finishes with a one-cycle done pulse that carries the captured read data.

Each phase length comes from a field of the configuration word. The strobe phase has one length for reads and another for writes. The same word selects 8-bit or 16-bit data width and whether the two byte lanes are exchanged. The configuration word is captured when the request is accepted, so it can change freely while a cycle is in flight.

Top module: `pio_strobe_seq`

## Requirements
- R1: After reset, `busy`, `done`, `dev_cs`, `dev_rd`, `dev_wr` and `dev_oe` are all low.
- R2: An accepted cycle holds `dev_cs` high without a gap for the setup, strobe and hold phases in that order. During the setup phase neither strobe is active. The strobe is active for the whole strobe phase. During the hold phase neither strobe is active.
- R3: A phase whose programmed length field is zero lasts exactly one clock.
- R4: Each phase length in clocks is read from a field of `cfg`:
  - setup: `cfg[11:9]`
  - read strobe: `cfg[8:5]`
  - write strobe: `cfg[4:2]`
  - hold: `cfg[1:0]`
- R5: `dev_rd` is asserted only in read cycles and `dev_wr` only in write cycles. The two are never high together, and neither is high while `dev_cs` is low.
- R6: `dev_oe` is high for every clock of a write cycle that has `dev_cs` high. It is low in read cycles. During a write cycle, `dev_dout` carries the lane-mapped write data (see R10).
- R7: Read data is taken from `dev_din` on the last clock of the strobe phase. It appears on `rdata` together with `done`.
- R8: `done` is a single-clock pulse in the clock after the last hold clock. In that clock `dev_cs` and `busy` are low. `busy` is high from the clock after acceptance through the last hold clock.
- R9: A request is accepted only while the sequencer is idle. A request held high during a cycle starts no further cycle once that cycle ends, provided it is dropped by the done clock.
- R10: `cfg[12]`=1 selects a 16-bit transfer; otherwise the transfer is 8 bits, in the low lane `[7:0]`. `cfg[13]`=1 exchanges lanes `[15:8]` and `[7:0]` on both write data and read data. In 8-bit mode with the exchange, the byte travels on `[15:8]`. In 8-bit mode, the unused lane of `dev_dout` and `rdata[15:8]` are zero.
- R11: `cfg`, `req_we`, `req_addr` and `req_wdata` are captured at acceptance. Changing them during a cycle has no effect on that cycle.
- R12: `dev_addr` equals the accepted address on every clock where `dev_cs` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 14 | Timing and width configuration word |
| req | input | 1 | Start a cycle (taken when idle) |
| req_we | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | ADDR_W | Peripheral register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data, valid with done |
| dev_cs | output | 1 | Device chip select |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_oe | output | 1 | Write data drive enable |
| dev_addr | output | ADDR_W | Device address |
| dev_dout | output | 16 | Data driven to the device |
| dev_din | input | 16 | Data returned by the device |

## Verification
The hardest case to reach from the ports is showing that the read sample is taken on exactly the last strobe clock, and not one clock earlier or later. To reach it, the stimulus drives a fresh random value on `dev_din` in every clock that `dev_rd` is high. It expects only the final one on `rdata`. Requirements R9 and R11 get the same kind of treatment. Within each cycle, the bench scrambles the configuration, address, data and direction right after acceptance and keeps `req` raised until the done clock. It then checks that the cycle still follows the captured values and that no second cycle begins. Strobe lengths cover both ends of every field, because zero and all-ones configuration words are mixed into the random ones.

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [13:0]       cfg,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rdata,
  output logic              dev_cs,
  output logic              dev_rd,
  output logic              dev_wr,
  output logic              dev_oe,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [15:0]       dev_dout,
  input  logic [15:0]       dev_din
);

  localparam int CW = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_t;

  phase_t          phase;
  logic [CW-1:0]   cnt;
  logic [13:0]     cfg_q;
  logic            we_q;
  logic [15:0]     wdata_q;
  logic [ADDR_W-1:0] addr_q;
  logic            done_q;
  logic [15:0]     rdata_q;

  function automatic logic [CW-1:0] min1(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

  logic [CW-1:0] setup_new, strobe_len, hold_len;
  assign setup_new  = min1({1'b0, cfg[11:9]});
  assign strobe_len = we_q ? min1({1'b0, cfg_q[4:2]}) : min1(cfg_q[8:5]);
  assign hold_len   = min1({2'b00, cfg_q[1:0]});

  logic accept, last;
  assign accept = (phase == PH_IDLE) && req;
  assign last   = (cnt == CW'(1));

  logic hw, swp;
  assign hw  = cfg_q[12];
  assign swp = cfg_q[13];

  logic [7:0] lane_lo, lane_hi;
  assign lane_lo = swp ? dev_din[15:8] : dev_din[7:0];
  assign lane_hi = swp ? dev_din[7:0]  : dev_din[15:8];

  logic [15:0] rd_map, wr_map;
  assign rd_map = hw ? {lane_hi, lane_lo} : {8'h00, lane_lo};
  assign wr_map = hw  ? (swp ? {wdata_q[7:0], wdata_q[15:8]} : wdata_q)
                      : (swp ? {wdata_q[7:0], 8'h00} : {8'h00, wdata_q[7:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      cfg_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase   <= PH_SETUP;
          cnt     <= setup_new;
          cfg_q   <= cfg;
          we_q    <= req_we;
          wdata_q <= req_wdata;
          addr_q  <= req_addr;
        end
        PH_SETUP: if (last) begin
          phase <= PH_STROBE;
          cnt   <= strobe_len;
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (last) begin
          phase <= PH_HOLD;
          cnt   <= hold_len;
          if (!we_q) rdata_q <= rd_map;
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (last) begin
          phase  <= PH_IDLE;
          done_q <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign dev_cs   = (phase != PH_IDLE);
  assign busy     = dev_cs;
  assign dev_rd   = (phase == PH_STROBE) && !we_q;
  assign dev_wr   = (phase == PH_STROBE) && we_q;
  assign dev_oe   = dev_cs && we_q;
  assign dev_addr = addr_q;
  assign dev_dout = we_q ? wr_map : 16'h0000;
  assign done     = done_q;
  assign rdata    = rdata_q;

endmodule

module pio_strobe_seq_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              dev_cs,
  input logic              dev_rd,
  input logic              dev_wr,
  input logic              dev_oe,
  input logic [ADDR_W-1:0] dev_addr
);

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_rd && dev_wr));

  a_r5_strobe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rd || dev_wr) |-> dev_cs);

  a_r6_wr_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr |-> dev_oe);

  a_r6_no_oe_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rd |-> !dev_oe);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !dev_cs));

  a_r2_cs_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_cs) |-> done);

  a_r12_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_cs && $past(dev_cs)) |-> $stable(dev_addr));

endmodule

bind pio_strobe_seq pio_strobe_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .dev_cs(dev_cs),
  .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_oe(dev_oe), .dev_addr(dev_addr)
);

// File: tb/tb_pio_strobe_seq.sv
module tb_pio_strobe_seq;
  localparam int AW = 10;

  logic clk = 0, rst_n = 0;
  logic [13:0] cfg = '0;
  logic req = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0, dev_din = '0;
  logic busy, done, dev_cs, dev_rd, dev_wr, dev_oe;
  logic [15:0] rdata, dev_dout;
  logic [AW-1:0] dev_addr;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  pio_strobe_seq #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .dev_cs(dev_cs), .dev_rd(dev_rd), .dev_wr(dev_wr),
    .dev_oe(dev_oe), .dev_addr(dev_addr), .dev_dout(dev_dout), .dev_din(dev_din)
  );

  function automatic int len1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [15:0] exp_dout(input logic [13:0] c, input logic [15:0] w);
    if (c[12]) return c[13] ? {w[7:0], w[15:8]} : w;
    return c[13] ? {w[7:0], 8'h00} : {8'h00, w[7:0]};
  endfunction

  function automatic logic [15:0] exp_rdata(input logic [13:0] c, input logic [15:0] d);
    logic [15:0] s;
    s = c[13] ? {d[7:0], d[15:8]} : d;
    return c[12] ? s : {8'h00, s[7:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_access(input logic [13:0] c, input bit w,
                            input logic [AW-1:0] a, input logic [15:0] d);
    int n_pre, n_str, n_post, cyc;
    bit bad_dir, bad_oe, bad_addr, bad_dout, bad_busy;
    logic [15:0] last_din;
    n_pre = 0; n_str = 0; n_post = 0; cyc = 0;
    bad_dir = 0; bad_oe = 0; bad_addr = 0; bad_dout = 0; bad_busy = 0;
    last_din = '0;
    @(negedge clk);
    cfg = c; req = 1; req_we = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    // R11 / R9: scramble inputs and keep requesting during the cycle
    cfg = 14'($urandom); req_we = ~w; req_addr = AW'($urandom); req_wdata = 16'($urandom);
    while (!done && cyc < 100) begin
      if (dev_cs) begin
        if (!busy) bad_busy = 1;
        if (dev_oe !== w) bad_oe = 1;
        if (dev_addr !== a) bad_addr = 1;
        if (w && dev_dout !== exp_dout(c, d)) bad_dout = 1;
        if (dev_rd || dev_wr) begin
          n_str++;
          if (dev_rd === w || dev_wr !== w) bad_dir = 1;
          if (n_post != 0) bad_dir = 1;
        end else if (n_str == 0) n_pre++;
        else n_post++;
        if (dev_rd) begin
          dev_din = 16'($urandom);
          last_din = dev_din;
        end
      end
      @(negedge clk);
      cyc++;
    end
    req = 0;
    chk(done === 1'b1, "R8 done seen", done, 1);
    chk(n_pre == len1(int'(c[11:9])), "R2/R4 setup length", n_pre, len1(int'(c[11:9])));
    if (w) chk(n_str == len1(int'(c[4:2])), "R4 write strobe length", n_str, len1(int'(c[4:2])));
    else   chk(n_str == len1(int'(c[8:5])), "R4 read strobe length", n_str, len1(int'(c[8:5])));
    chk(n_post == len1(int'(c[1:0])), "R3/R4 hold length", n_post, len1(int'(c[1:0])));
    chk(!bad_dir, "R5 strobe direction", bad_dir, 0);
    chk(!bad_oe, "R6 data enable", bad_oe, 0);
    chk(!bad_addr, "R12 address held", bad_addr, 0);
    chk(!bad_busy, "R8 busy during cycle", bad_busy, 0);
    if (w) chk(!bad_dout, "R10/R11 write lanes", bad_dout, 0);
    else chk(rdata === exp_rdata(c, last_din), "R7/R10 read data", rdata, exp_rdata(c, last_din));
    chk(!dev_cs && !busy, "R8 idle at done", {dev_cs, busy}, 0);
    @(negedge clk);
    chk(!done, "R8 done one clock", done, 0);
    @(negedge clk);
    chk(!dev_cs && !busy, "R9 held request ignored", {dev_cs, busy}, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #23;
    chk({busy, done, dev_cs, dev_rd, dev_wr, dev_oe} === 6'b0, "R1 reset outputs",
        {busy, done, dev_cs, dev_rd, dev_wr, dev_oe}, 0);
    rst_n = 1;
    // directed corners: all-zero fields (R3), all-ones, each width/swap mode
    run_access(14'h0000, 1'b0, 10'h155, 16'h0000);
    run_access(14'h0000, 1'b1, 10'h2aa, 16'hA55A);
    run_access(14'h3fff, 1'b0, 10'h3ff, 16'h0000);
    run_access(14'h3fff, 1'b1, 10'h001, 16'h1234);
    run_access(14'h1000 | 14'h0a52, 1'b1, 10'h010, 16'hBEEF);
    run_access(14'h2000 | 14'h0a52, 1'b1, 10'h011, 16'hBEEF);
    run_access(14'h2000 | 14'h0a52, 1'b0, 10'h012, 16'h0000);
    run_access(14'h1000 | 14'h01e0, 1'b0, 10'h013, 16'h0000);
    for (int i = 0; i < 400; i++)
      run_access(14'($urandom), 1'($urandom), AW'($urandom), 16'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule